// File: doc/BRIEF.md
# Integer Add Subtract Carry Unit

This is a purely combinational add/subtract datapath for the fixed-point stage of a RISC pipeline. Each operation is formed as one pass through a single adder, `X + Y + Cin`. `X` is either the first register operand, its bitwise complement, a literal zero or the next-instruction address. `Y` is the second register operand, a sign-extended immediate, a shifted immediate, all ones or zero. `Cin` is 0, 1, the carry bit or the alternate-carry bit.

Beside the sum, the block reports three things, each with its own write strobe: a new carry bit, a new overflow bit with the sticky summary-overflow bit, and a four-bit condition field. The surrounding pipeline decodes the instruction and supplies the operation code, the overflow-enable bit, the record bit and the "register field is zero" flag. It also commits the outputs whose strobes are raised.

Top module: `addsub_carry_unit`

## Requirements
- R1: `op_sel` 0 gives `opa + opb`. Code 4 gives `opb - opa`, formed as complement of opa plus opb plus one. Code 15 gives the two's-complement negation of opa. None of the three writes the carry (`ca_we`=0, `ca_out`=`ca_in`).
- R2: Code 1 adds the sign-extended `imm` to opa. With `ra_is_zero`=1 the result is the extended immediate alone, whatever opa holds.
- R3: Code 2 adds `imm` with sixteen zero bits appended and then sign-extended, to opa, or to zero when `ra_is_zero`=1. Code 3 adds that same shifted value to `nia`.
- R4: The carrying forms raise `ca_we` and set `ca_out` to the unsigned carry out of the most significant bit. They are code 5 (opa + sign-extended imm), code 6 (complement of opa + sign-extended imm + 1), code 7 (opa + opb) and code 8 (complement of opa + opb + 1). Every other code except 9..14 leaves `ca_out` equal to `ca_in`.
- R5: The extended forms take `ca_in` as carry in and write the carry out. They are code 9 (opa+opb), code 10 (~opa+opb), code 11 (opa+all ones), code 12 (~opa+all ones), code 13 (opa+0) and code 14 (~opa+0).
- R6: For codes 0, 4 and 7..15 with `oe`=1, `ov_we`=1. In that case `ov_out` is the signed overflow, meaning the carries into and out of the MSB differ, and `so_out` = `so_in` OR that overflow. Otherwise `so_out`=`so_in`.
- R7: Code 16 computes opa + opb + `ov_in`. It always raises `ov_we` with `ov_out` equal to the carry out. It leaves the carry (`ca_we`=0) and `so_out` untouched and ignores `oe`.
- R8: When the condition field is recorded, `cr` holds {negative, positive, zero, so_out} of the 64-bit result. These sit at bits 3, 2, 1, 0.
- R9: `cr_we` = `rc` for every code except 1, 2, 3 and 6, which never record. `oe` has no effect on codes 1, 2, 3, 5 and 6 (`ov_we`=0, `ov_out`=`ov_in`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation code (0..16) |
| opa | input | 64 | First register operand |
| opb | input | 64 | Second register operand |
| imm | input | 16 | Signed immediate |
| nia | input | 64 | Next-instruction address |
| ra_is_zero | input | 1 | First register field is zero (immediate adds) |
| ca_in | input | 1 | Current carry bit |
| ov_in | input | 1 | Current overflow / alternate carry bit |
| so_in | input | 1 | Current summary-overflow bit |
| oe | input | 1 | Overflow-enable bit of the instruction |
| rc | input | 1 | Record bit of the instruction |
| result | output | 64 | Sum |
| ca_out | output | 1 | New carry bit |
| ca_we | output | 1 | Carry write strobe |
| ov_out | output | 1 | New overflow bit |
| ov_we | output | 1 | Overflow write strobe |
| so_out | output | 1 | New summary-overflow bit |
| cr | output | 4 | Condition field {lt, gt, eq, so} |
| cr_we | output | 1 | Condition field write strobe |

## Verification
The hardest cases sit at the edges of the carry-in forms. One is the minus-one subtract with an all-ones operand and a clear carry, the only input that drops its carry out. Another is the zero forms, which carry only at one operand value. A third is signed overflow on the complement path near the most negative number. The stimulus crosses every code with a set of boundary operands (0, 1, all ones, the extreme signed values and mixed patterns), both carry-in values, both alternate-carry values and all `oe`/`rc`/`ra_is_zero` combinations. A model computes the expected values as exact unsigned and signed integer sums.

// File: rtl/addsub_carry_unit.sv
module addsub_carry_unit #(
  parameter int XLEN = 64,
  parameter int IMMW = 16
) (
  input  logic [4:0]      op_sel,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [IMMW-1:0] imm,
  input  logic [XLEN-1:0] nia,
  input  logic            ra_is_zero,
  input  logic            ca_in,
  input  logic            ov_in,
  input  logic            so_in,
  input  logic            oe,
  input  logic            rc,
  output logic [XLEN-1:0] result,
  output logic            ca_out,
  output logic            ca_we,
  output logic            ov_out,
  output logic            ov_we,
  output logic            so_out,
  output logic [3:0]      cr,
  output logic            cr_we
);
  localparam int MSB = XLEN - 1;
  localparam logic [4:0] OP_ADD    = 5'd0,  OP_ADDI  = 5'd1,  OP_ADDIS  = 5'd2;
  localparam logic [4:0] OP_ADDPC  = 5'd3,  OP_SUBF  = 5'd4,  OP_ADDIC  = 5'd5;
  localparam logic [4:0] OP_SUBFIC = 5'd6,  OP_ADDC  = 5'd7,  OP_SUBFC  = 5'd8;
  localparam logic [4:0] OP_ADDE   = 5'd9,  OP_SUBFE = 5'd10, OP_ADDME  = 5'd11;
  localparam logic [4:0] OP_SUBFME = 5'd12, OP_ADDZE = 5'd13, OP_SUBFZE = 5'd14;
  localparam logic [4:0] OP_NEG    = 5'd15, OP_ALTX  = 5'd16;

  logic [XLEN-1:0] imm_sx, imm_sh, x, y;
  logic            cin, carry, ovf, alt, oe_form, rec_form;
  logic [XLEN:0]   sum;

  assign imm_sx = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
  assign imm_sh = {{(XLEN-2*IMMW){imm[IMMW-1]}}, imm, {IMMW{1'b0}}};

  always_comb begin
    x = opa;
    y = opb;
    cin = 1'b0;
    ca_we = 1'b0;
    unique case (op_sel)
      OP_ADD:    ;
      OP_ADDI:   begin x = ra_is_zero ? '0 : opa; y = imm_sx; end
      OP_ADDIS:  begin x = ra_is_zero ? '0 : opa; y = imm_sh; end
      OP_ADDPC:  begin x = nia; y = imm_sh; end
      OP_SUBF:   begin x = ~opa; cin = 1'b1; end
      OP_ADDIC:  begin y = imm_sx; ca_we = 1'b1; end
      OP_SUBFIC: begin x = ~opa; y = imm_sx; cin = 1'b1; ca_we = 1'b1; end
      OP_ADDC:   ca_we = 1'b1;
      OP_SUBFC:  begin x = ~opa; cin = 1'b1; ca_we = 1'b1; end
      OP_ADDE:   begin cin = ca_in; ca_we = 1'b1; end
      OP_SUBFE:  begin x = ~opa; cin = ca_in; ca_we = 1'b1; end
      OP_ADDME:  begin y = '1; cin = ca_in; ca_we = 1'b1; end
      OP_SUBFME: begin x = ~opa; y = '1; cin = ca_in; ca_we = 1'b1; end
      OP_ADDZE:  begin y = '0; cin = ca_in; ca_we = 1'b1; end
      OP_SUBFZE: begin x = ~opa; y = '0; cin = ca_in; ca_we = 1'b1; end
      OP_NEG:    begin x = ~opa; y = '0; cin = 1'b1; end
      OP_ALTX:   cin = ov_in;
      default:   ;
    endcase
  end

  assign sum    = {1'b0, x} + {1'b0, y} + {{XLEN{1'b0}}, cin};
  assign result = sum[MSB:0];
  assign carry  = sum[XLEN];
  assign ovf    = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);

  assign alt      = (op_sel == OP_ALTX);
  assign oe_form  = (op_sel == OP_ADD) || (op_sel == OP_SUBF) ||
                    (op_sel >= OP_ADDC && op_sel <= OP_NEG);
  assign rec_form = (op_sel <= OP_ALTX) && !(op_sel inside {OP_ADDI, OP_ADDIS, OP_ADDPC, OP_SUBFIC});

  assign ca_out = ca_we ? carry : ca_in;
  assign ov_we  = alt || (oe_form && oe);
  assign ov_out = alt ? carry : ((oe_form && oe) ? ovf : ov_in);
  assign so_out = so_in || (oe_form && oe && ovf);
  assign cr_we  = rc && rec_form;
  assign cr     = {result[MSB], !result[MSB] && (result != '0), result == '0, so_out};

  always_comb begin
    if (!$isunknown({op_sel, opa, opb, imm, ra_is_zero, ca_in, ov_in, so_in, oe, rc})) begin
      p_add_inverse_r1: assert (op_sel != OP_ADD || result - opb == opa)
        else $error("add result inconsistent");
      p_subf_inverse_r1: assert (op_sel != OP_SUBF || result + opa == opb)
        else $error("subtract-from result inconsistent");
      p_zero_field_r2: assert (!(op_sel == OP_ADDI && ra_is_zero) || result == imm_sx)
        else $error("zero register field not honoured");
      p_ca_hold_r4: assert (ca_we || ca_out == ca_in)
        else $error("carry changed without strobe");
      p_so_sticky_r6: assert (!so_in || so_out)
        else $error("summary overflow cleared");
      p_alt_route_r7: assert (!alt || (ov_we && !ca_we && so_out == so_in))
        else $error("alternate carry routing wrong");
      p_cr_onehot_r8: assert ($onehot(cr[3:1]))
        else $error("condition flags not one-hot");
    end
  end
endmodule

// File: tb/tb_addsub_carry_unit.sv
module tb_addsub_carry_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [4:0]  op_sel;
  logic [63:0] opa, opb, nia, result;
  logic [15:0] imm;
  logic ra_is_zero, ca_in, ov_in, so_in, oe, rc;
  logic ca_out, ca_we, ov_out, ov_we, so_out, cr_we;
  logic [3:0] cr;

  addsub_carry_unit dut (.*);

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  localparam logic [65:0] MAXU = {2'b00, {64{1'b1}}};

  logic [63:0] pats [8] = '{64'h0, 64'h1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
                            64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_5555_5555_5555,
                            64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_0000_0001};

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s op=%0d actual=%h expected=%h", tag, op_sel, act, exp);
    end
  endtask

  function automatic logic signed [65:0] sx(input logic [63:0] v);
    return {{2{v[63]}}, v};
  endfunction

  task automatic run_case();
    logic [65:0] ue, ua, uy, unx;
    logic signed [65:0] se, sa, sy;
    logic [63:0] isx, ish;
    bit carry, ovf, wr_ca, oe_f, rec_f, alt, exp_ovwe, exp_ov, exp_so;
    string rtag;
    isx = {{48{imm[15]}}, imm};
    ish = {{32{imm[15]}}, imm, 16'h0};
    ua = {2'b0, opa};
    unx = MAXU - ua;
    sa = sx(opa);
    ue = '0; se = '0;
    case (op_sel)
      0:  begin ue = ua + opb;               se = sa + sx(opb); end
      1:  begin uy = ra_is_zero ? 66'd0 : ua; sy = ra_is_zero ? 66'sd0 : sa;
                ue = uy + isx; se = sy + sx(isx); end
      2:  begin uy = ra_is_zero ? 66'd0 : ua; sy = ra_is_zero ? 66'sd0 : sa;
                ue = uy + ish; se = sy + sx(ish); end
      3:  begin ue = {2'b0, nia} + ish;      se = sx(nia) + sx(ish); end
      4, 8: begin ue = unx + opb + 1;        se = sx(opb) - sa; end
      5:  begin ue = ua + isx;               se = sa + sx(isx); end
      6:  begin ue = unx + isx + 1;          se = sx(isx) - sa; end
      7:  begin ue = ua + opb;               se = sa + sx(opb); end
      9:  begin ue = ua + opb + ca_in;       se = sa + sx(opb) + ca_in; end
      10: begin ue = unx + opb + ca_in;      se = sx(opb) - sa - 1 + ca_in; end
      11: begin ue = ua + MAXU + ca_in;      se = sa - 1 + ca_in; end
      12: begin ue = unx + MAXU + ca_in;     se = -sa - 2 + ca_in; end
      13: begin ue = ua + ca_in;             se = sa + ca_in; end
      14: begin ue = unx + ca_in;            se = -sa - 1 + ca_in; end
      15: begin ue = unx + 1;                se = -sa; end
      default: begin ue = ua + opb + ov_in;  se = sa + sx(opb) + ov_in; end
    endcase
    carry = ue[64];
    ovf = (se > 66'sh0_7FFF_FFFF_FFFF_FFFF) || (se < -66'sh0_8000_0000_0000_0000);
    wr_ca = (op_sel >= 5 && op_sel <= 14);
    oe_f  = (op_sel == 0 || op_sel == 4 || (op_sel >= 7 && op_sel <= 15));
    rec_f = !(op_sel inside {5'd1, 5'd2, 5'd3, 5'd6});
    alt   = (op_sel == 16);
    exp_ovwe = alt || (oe_f && oe);
    exp_ov = alt ? carry : ((oe_f && oe) ? ovf : ov_in);
    exp_so = so_in || (oe_f && oe && ovf);
    case (op_sel)
      0, 4, 15: rtag = "R1";
      1:        rtag = "R2";
      2, 3:     rtag = "R3";
      5, 6, 7, 8: rtag = "R4";
      16:       rtag = "R7";
      default:  rtag = "R5";
    endcase
    chk(result == ue[63:0], rtag, result, ue[63:0]);
    chk(ca_we == wr_ca && ca_out == (wr_ca ? carry : ca_in), wr_ca ? "R4 carry" : "R4 carry hold",
        {ca_we, ca_out}, {wr_ca, (wr_ca ? carry : ca_in)});
    chk(ov_we == exp_ovwe && ov_out == exp_ov,
        alt ? "R7 ov" : ((op_sel inside {5'd1, 5'd2, 5'd3, 5'd5, 5'd6}) ? "R9 oe ignored" : "R6 ov"),
        {ov_we, ov_out}, {exp_ovwe, exp_ov});
    chk(so_out == exp_so, "R6 so", so_out, exp_so);
    chk(cr_we == (rc && rec_f), rec_f ? "R8 cr_we" : "R9 no record", cr_we, rc && rec_f);
    if (cr_we)
      chk(cr == {ue[63], !ue[63] && ue[63:0] != 0, ue[63:0] == 0, exp_so}, "R8 cr", cr,
          {ue[63], !ue[63] && ue[63:0] != 0, ue[63:0] == 0, exp_so});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<200000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    op_sel = 0; opa = 0; opb = 0; imm = 0; nia = 0;
    ra_is_zero = 0; ca_in = 0; ov_in = 0; so_in = 0; oe = 0; rc = 1;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(result == 0 && cr == 4'b0010 && !ca_we && !ov_we && cr_we, "R8 idle zero", {cr, result[59:0]}, 64'h2000_0000_0000_0000 | (64'(cr_we) << 0) ^ 64'(cr_we));
    for (int o = 0; o <= 16; o++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int f = 0; f < 32; f++) begin
            @(posedge clk);
            op_sel = 5'(o); opa = pats[i]; opb = pats[j];
            imm = pats[j][15:0] ^ pats[i][31:16];
            nia = pats[j] ^ 64'h1000;
            ca_in = f[0]; ov_in = f[1]; oe = f[2]; rc = f[3]; ra_is_zero = f[4];
            so_in = f[0] ^ f[2];
            @(negedge clk);
            run_case();
          end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule